// File: doc/BRIEF.md
# Dual-Converter DAC Command Sequencer

This block sits between a byte-wide host register port and one or two four-channel serial digital-to-analog converters. For each converter the host stages a 16-bit word in two byte registers and then writes a command byte. The upper nibble of the command byte picks an operation. The operation can write an output span, write a code, transfer staged values to the active outputs, combine a write with a transfer, or read back a stored value. Command bits 2:1 pick one channel, and a low nibble of all ones addresses every channel.

An accepted command clears the converter's ready flag. The block then shifts a 24-bit frame to that converter: the command byte first, then the staged word, most significant bit first. The ready flag sets again when the last bit has gone out. The block keeps a shadow copy of every channel's staged ("input") and active span and code, so it can answer readback commands. A readback command loads the selected shadow value into the data registers, where the host can read it.

Top module: `dac_cmd_seq`

## Requirements
- R1: After reset, every converter's status byte reads 0x80 (ready set), its data bytes read 0x00, its chip select is high and its serial clock is low.
- R2: A command write while ready clears ready and sends a 24-bit frame while chip select is low, most significant bit first, valid at each rising serial-clock edge. The frame is the command byte followed by data bits 15..0. Ready sets again when chip select returns high.
- R3: Opcode 0x3 stores the 16-bit data word as the selected channel's input code, and opcode 0x2 stores the data's low four bits as its input span. Neither opcode changes the active values. The channel is given by command bits 2:1.
- R4: Opcode 0x4 copies the selected channel's input span and code to its active span and code. Opcode 0x5 does the same for every channel.
- R5: Opcodes 0x6/0x7 write span/code and then update the selected channel. Opcodes 0x8/0x9 write span/code and then update all channels. A command low nibble of 0xF applies the write to all channels.
- R6: Readback opcodes load a value of the selected channel into the data registers: 0xA input span, 0xB input code, 0xC active span, 0xD active code. The frame of that command carries the data held before the load.
- R7: Per converter, data low byte is at offset 0, data high byte at 1, command at 2 (reads back the last accepted command) and status at 3 (bit 7 = ready). The second converter's registers sit 4 above and work independently.
- R8: A command write while the converter is not ready is ignored: no new frame, no shadow change, and the command register keeps its value.
- R9: Opcode 0xF and the unassigned opcodes 0x0, 0x1 and 0xE send a frame but leave all shadow values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset: bit 2 picks the converter, bits 1:0 the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| dac_cs_n | output | N_DAC | Per-converter frame select, active low |
| dac_sck | output | N_DAC | Per-converter serial clock |
| dac_sdo | output | N_DAC | Per-converter serial data |

## Verification
The bench builds the block with two converters and a serial-clock divider of 2. With two converters it can show that the second converter's offset window works and that a frame on one converter leaves the other's ready flag alone. The short divider keeps each 24-bit frame at 96 cycles. That leaves room for commands issued mid-frame, all-channel writes with and without update, and readbacks of all four shadow kinds.

// File: rtl/dac_cmd_seq_pkg.sv
package dac_cmd_seq_pkg;

   typedef enum logic [3:0] {
      OP_SPAN        = 4'h2,
      OP_CODE        = 4'h3,
      OP_UPD         = 4'h4,
      OP_UPD_ALL     = 4'h5,
      OP_SPAN_UPD    = 4'h6,
      OP_CODE_UPD    = 4'h7,
      OP_SPAN_UPDALL = 4'h8,
      OP_CODE_UPDALL = 4'h9,
      OP_RB_IN_SPAN  = 4'hA,
      OP_RB_IN_CODE  = 4'hB,
      OP_RB_ACT_SPAN = 4'hC,
      OP_RB_ACT_CODE = 4'hD,
      OP_IDLE        = 4'hF
   } opcode_e;

   typedef struct packed {
      logic       wr_span;
      logic       wr_code;
      logic       upd_one;
      logic       upd_all;
      logic       rb_en;
      logic [1:0] rb_kind;
      logic       every_ch;
      logic [1:0] ch;
   } cmd_dec_t;

   localparam logic [1:0] REG_DLO  = 2'd0;
   localparam logic [1:0] REG_DHI  = 2'd1;
   localparam logic [1:0] REG_CMD  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CMD_W = 8;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_cmd_seq_pkg::*;
(
   input  logic [CMD_W-1:0] cmd_byte,
   output cmd_dec_t         dec
);

   always_comb begin
      dec          = '0;
      dec.ch       = cmd_byte[2:1];
      dec.every_ch = (cmd_byte[3:0] == 4'hF);
      case (cmd_byte[7:4])
         OP_SPAN:        dec.wr_span = 1'b1;
         OP_CODE:        dec.wr_code = 1'b1;
         OP_UPD:         dec.upd_one = 1'b1;
         OP_UPD_ALL:     dec.upd_all = 1'b1;
         OP_SPAN_UPD:    begin dec.wr_span = 1'b1; dec.upd_one = 1'b1; end
         OP_CODE_UPD:    begin dec.wr_code = 1'b1; dec.upd_one = 1'b1; end
         OP_SPAN_UPDALL: begin dec.wr_span = 1'b1; dec.upd_all = 1'b1; end
         OP_CODE_UPDALL: begin dec.wr_code = 1'b1; dec.upd_all = 1'b1; end
         OP_RB_IN_SPAN:  begin dec.rb_en = 1'b1; dec.rb_kind = 2'd0; end
         OP_RB_IN_CODE:  begin dec.rb_en = 1'b1; dec.rb_kind = 2'd1; end
         OP_RB_ACT_SPAN: begin dec.rb_en = 1'b1; dec.rb_kind = 2'd2; end
         OP_RB_ACT_CODE: begin dec.rb_en = 1'b1; dec.rb_kind = 2'd3; end
         default:        ;
      endcase
   end

endmodule

// File: rtl/dac_chan_shadow.sv
module dac_chan_shadow
   import dac_cmd_seq_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int DATA_W = 16,
   parameter int SPAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  cmd_dec_t          dec,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rb_data
);

   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   logic [SPAN_W-1:0] in_span  [N_CH];
   logic [DATA_W-1:0] in_code  [N_CH];
   logic [SPAN_W-1:0] act_span [N_CH];
   logic [DATA_W-1:0] act_code [N_CH];

   logic [CH_W-1:0] rb_ch;
   assign rb_ch = dec.ch[CH_W-1:0];

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic              hit;
      logic              upd;
      logic [SPAN_W-1:0] span_nxt;
      logic [DATA_W-1:0] code_nxt;

      assign hit      = dec.every_ch || (rb_ch == CH_W'(c));
      assign upd      = dec.upd_all || (dec.upd_one && hit);
      assign span_nxt = (dec.wr_span && hit) ? wr_data[SPAN_W-1:0] : in_span[c];
      assign code_nxt = (dec.wr_code && hit) ? wr_data : in_code[c];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_span[c]  <= '0;
            in_code[c]  <= '0;
            act_span[c] <= '0;
            act_code[c] <= '0;
         end else if (apply) begin
            in_span[c] <= span_nxt;
            in_code[c] <= code_nxt;
            if (upd) begin
               act_span[c] <= span_nxt;
               act_code[c] <= code_nxt;
            end
         end
      end
   end

   always_comb begin
      case (dec.rb_kind)
         2'd0:    rb_data = DATA_W'(in_span[rb_ch]);
         2'd1:    rb_data = in_code[rb_ch];
         2'd2:    rb_data = DATA_W'(act_span[rb_ch]);
         default: rb_data = act_code[rb_ch];
      endcase
   end

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx #(
   parameter int FRAME_W = 24,
   parameter int SCK_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               done,
   output logic               cs_n,
   output logic               sck,
   output logic               sdo
);

   localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
   localparam int BIT_W = $clog2(FRAME_W);

   logic               active;
   logic               sck_q;
   logic [DIV_W-1:0]   div_cnt;
   logic [BIT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] shreg;
   logic               div_hit;
   logic               fall;

   assign div_hit = (div_cnt == DIV_W'(SCK_DIV - 1));
   assign fall    = active && div_hit && sck_q;
   assign done    = fall && (bit_cnt == BIT_W'(FRAME_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sck_q   <= 1'b0;
         div_cnt <= '0;
         bit_cnt <= '0;
         shreg   <= '0;
      end else if (!active) begin
         if (start) begin
            active  <= 1'b1;
            shreg   <= frame;
            sck_q   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
         end
      end else if (div_hit) begin
         div_cnt <= '0;
         sck_q   <= ~sck_q;
         if (fall) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            if (done) begin
               active <= 1'b0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   assign cs_n = ~active;
   assign sck  = sck_q;
   assign sdo  = active & shreg[FRAME_W-1];

endmodule

// File: rtl/dac_cmd_seq.sv
module dac_cmd_seq
   import dac_cmd_seq_pkg::*;
#(
   parameter int N_DAC   = 2,
   parameter int N_CH    = 4,
   parameter int DATA_W  = 16,
   parameter int SPAN_W  = 4,
   parameter int SCK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       bus_addr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic [N_DAC-1:0] dac_cs_n,
   output logic [N_DAC-1:0] dac_sck,
   output logic [N_DAC-1:0] dac_sdo
);

   localparam int WORD_W  = 16;
   localparam int HI_W    = DATA_W - 8;
   localparam int FRAME_W = CMD_W + WORD_W;

   if (N_DAC < 1 || N_DAC > 2) begin : g_bad_ndac
      $error("dac_cmd_seq: N_DAC must be 1 or 2");
   end
   if (N_CH != 2 && N_CH != 4) begin : g_bad_nch
      $error("dac_cmd_seq: N_CH must be 2 or 4");
   end
   if (DATA_W < 9 || DATA_W > WORD_W) begin : g_bad_data
      $error("dac_cmd_seq: DATA_W must lie in 9..16");
   end
   if (SPAN_W < 1 || SPAN_W > 8) begin : g_bad_span
      $error("dac_cmd_seq: SPAN_W must lie in 1..8");
   end
   if (SCK_DIV < 2) begin : g_bad_div
      $error("dac_cmd_seq: SCK_DIV must be at least 2");
   end

   logic [N_DAC-1:0] ready_vec;
   logic [7:0]       rd_vec [N_DAC];
   cmd_dec_t         dec;

   dac_cmd_decode u_dec (
      .cmd_byte (bus_wdata),
      .dec      (dec)
   );

   for (genvar d = 0; d < N_DAC; d++) begin : g_dac
      logic              sel;
      logic              start;
      logic              tx_done;
      logic              ready_q;
      logic [DATA_W-1:0] hold_q;
      logic [CMD_W-1:0]  cmd_q;
      logic [DATA_W-1:0] rb_data;

      if (N_DAC == 1) begin : g_one
         assign sel = 1'b1;
      end else begin : g_two
         assign sel = (bus_addr[2] == 1'(d));
      end

      assign start = bus_wr && sel && (bus_addr[1:0] == REG_CMD) && ready_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ready_q <= 1'b1;
            hold_q  <= '0;
            cmd_q   <= '0;
         end else begin
            if (start) begin
               ready_q <= 1'b0;
               cmd_q   <= bus_wdata;
               if (dec.rb_en) begin
                  hold_q <= rb_data;
               end
            end else if (tx_done) begin
               ready_q <= 1'b1;
            end
            if (bus_wr && sel && bus_addr[1:0] == REG_DLO) begin
               hold_q[7:0] <= bus_wdata;
            end
            if (bus_wr && sel && bus_addr[1:0] == REG_DHI) begin
               hold_q[DATA_W-1:8] <= bus_wdata[HI_W-1:0];
            end
         end
      end

      dac_chan_shadow #(
         .N_CH   (N_CH),
         .DATA_W (DATA_W),
         .SPAN_W (SPAN_W)
      ) u_shadow (
         .clk     (clk),
         .rst_n   (rst_n),
         .apply   (start),
         .dec     (dec),
         .wr_data (hold_q),
         .rb_data (rb_data)
      );

      dac_frame_tx #(
         .FRAME_W (FRAME_W),
         .SCK_DIV (SCK_DIV)
      ) u_tx (
         .clk   (clk),
         .rst_n (rst_n),
         .start (start),
         .frame ({bus_wdata, WORD_W'(hold_q)}),
         .done  (tx_done),
         .cs_n  (dac_cs_n[d]),
         .sck   (dac_sck[d]),
         .sdo   (dac_sdo[d])
      );

      assign ready_vec[d] = ready_q;

      always_comb begin
         case (bus_addr[1:0])
            REG_DLO: rd_vec[d] = hold_q[7:0];
            REG_DHI: rd_vec[d] = 8'(hold_q[DATA_W-1:8]);
            REG_CMD: rd_vec[d] = cmd_q;
            default: rd_vec[d] = {ready_q, 7'b0};
         endcase
      end
   end

   if (N_DAC == 1) begin : g_rd_one
      assign bus_rdata = rd_vec[0];
   end else begin : g_rd_two
      assign bus_rdata = rd_vec[bus_addr[2]];
   end

endmodule

// File: rtl/dac_cmd_seq_chk.sv
module dac_cmd_seq_chk #(
   parameter int N_DAC = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [2:0]       bus_addr,
   input logic [N_DAC-1:0] ready,
   input logic [N_DAC-1:0] cs_n,
   input logic [N_DAC-1:0] sck
);

   for (genvar d = 0; d < N_DAC; d++) begin : g_chk
      logic hit;
      assign hit = (N_DAC == 1) || (bus_addr[2] == 1'(d));

      // R2
      accept_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && hit && bus_addr[1:0] == 2'd2 && ready[d]) |=> !ready[d]);

      // R2
      idle_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ready[d] |-> cs_n[d]);

      // R2
      idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cs_n[d] |-> !sck[d]);

      // R2
      ready_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready[d]) |-> $rose(cs_n[d]));
   end

endmodule

bind dac_cmd_seq dac_cmd_seq_chk #(.N_DAC(N_DAC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .ready    (ready_vec),
   .cs_n     (dac_cs_n),
   .sck      (dac_sck)
);

// File: tb/test_dac_cmd_seq.sv
module test_dac_cmd_seq;

   localparam int N_DAC = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic [2:0]       bus_addr = '0;
   logic [7:0]       bus_wdata = '0;
   logic [7:0]       bus_rdata;
   logic [N_DAC-1:0] dac_cs_n, dac_sck, dac_sdo;

   int checks = 0;
   int fails  = 0;

   logic [23:0] cap0 = '0, cap1 = '0;
   int          cnt0 = 0, cnt1 = 0;

   always #10 clk = ~clk;

   dac_cmd_seq #(.N_DAC(N_DAC), .N_CH(4), .DATA_W(16), .SPAN_W(4), .SCK_DIV(2)) i_dac_cmd_seq (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dac_cs_n(dac_cs_n), .dac_sck(dac_sck), .dac_sdo(dac_sdo)
   );

   always @(negedge dac_cs_n[0]) cnt0 = 0;
   always @(negedge dac_cs_n[1]) cnt1 = 0;
   always @(posedge dac_sck[0]) begin cap0 = {cap0[22:0], dac_sdo[0]}; cnt0++; end
   always @(posedge dac_sck[1]) begin cap1 = {cap1[22:0], dac_sdo[1]}; cnt1++; end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      bus_addr = 3'(a);
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_ready(input int dac);
      logic [7:0] s;
      for (int n = 0; n < 2000; n++) begin
         rd(dac * 4 + 3, s);
         if (s[7]) return;
         @(negedge clk);
      end
   endtask

   task automatic stage(input int dac, input logic [15:0] v);
      wr(dac * 4 + 0, v[7:0]);
      wr(dac * 4 + 1, v[15:8]);
   endtask

   task automatic issue(input int dac, input logic [15:0] v, input logic [7:0] c);
      stage(dac, v);
      wr(dac * 4 + 2, c);
      wait_ready(dac);
   endtask

   task automatic readback(input int dac, input logic [7:0] c, output logic [15:0] v);
      logic [7:0] lo, hi;
      wr(dac * 4 + 2, c);
      wait_ready(dac);
      rd(dac * 4 + 0, lo);
      rd(dac * 4 + 1, hi);
      v = {hi, lo};
   endtask

   task automatic t_reset;
      logic [7:0] b;
      rd(3, b);  chk("R1 status dac0", 32'(b), 32'h80);
      rd(7, b);  chk("R1 status dac1", 32'(b), 32'h80);
      rd(0, b);  chk("R1 data low", 32'(b), 32'h00);
      rd(5, b);  chk("R1 data high dac1", 32'(b), 32'h00);
      chk("R1 idle select", 32'(dac_cs_n), 32'h3);
      chk("R1 idle sck", 32'(dac_sck), 32'h0);
   endtask

   task automatic t_frame;
      logic [7:0]  b;
      logic [15:0] v;
      stage(0, 16'h1234);
      wr(2, 8'h32);
      rd(3, b);
      chk("R2 ready clears", 32'(b), 32'h00);
      chk("R2 select low", 32'(dac_cs_n[0]), 32'h0);
      wait_ready(0);
      chk("R2 frame bits", 32'(cap0), 32'h321234);
      chk("R2 frame length", 32'(cnt0), 32'd24);
      rd(2, b);
      chk("R7 command readback", 32'(b), 32'h32);
      readback(0, 8'hB2, v); chk("R3 input code ch1", 32'(v), 32'h1234);
      readback(0, 8'hD2, v); chk("R3 active code untouched", 32'(v), 32'h0);
      issue(0, 16'h00A7, 8'h24);
      readback(0, 8'hA4, v); chk("R3 input span low nibble", 32'(v), 32'h7);
      readback(0, 8'hC4, v); chk("R3 active span untouched", 32'(v), 32'h0);
   endtask

   task automatic t_update;
      logic [15:0] v;
      issue(0, 16'h0000, 8'h42);
      readback(0, 8'hD2, v); chk("R4 update ch1 code", 32'(v), 32'h1234);
      readback(0, 8'hC4, v); chk("R4 ch2 span not yet moved", 32'(v), 32'h0);
      issue(0, 16'h0000, 8'h50);
      readback(0, 8'hC4, v); chk("R4 update all moves ch2 span", 32'(v), 32'h7);
   endtask

   task automatic t_readback;
      logic [15:0] v;
      stage(0, 16'h4321);
      readback(0, 8'hB2, v);
      chk("R6 frame carries prior data", 32'(cap0), 32'hB24321);
      chk("R6 loaded value", 32'(v), 32'h1234);
   endtask

   task automatic t_combined;
      logic [15:0] v;
      issue(0, 16'h0005, 8'h8F);
      readback(0, 8'hA0, v); chk("R5 span to all ch0", 32'(v), 32'h5);
      readback(0, 8'hC6, v); chk("R5 span update all ch3", 32'(v), 32'h5);
      issue(0, 16'hBEEF, 8'h7F);
      readback(0, 8'hD0, v); chk("R5 code all ch0", 32'(v), 32'hBEEF);
      issue(0, 16'h1111, 8'h76);
      readback(0, 8'hD6, v); chk("R5 single update ch3", 32'(v), 32'h1111);
      readback(0, 8'hD0, v); chk("R5 ch0 kept", 32'(v), 32'hBEEF);
   endtask

   task automatic t_second;
      logic [7:0]  b;
      logic [15:0] v;
      stage(1, 16'h5678);
      wr(6, 8'h74);
      rd(3, b);
      chk("R7 other converter stays ready", 32'(b), 32'h80);
      wait_ready(1);
      chk("R7 second frame", 32'(cap1), 32'h745678);
      readback(1, 8'hD4, v); chk("R7 second active ch2", 32'(v), 32'h5678);
      readback(0, 8'hD4, v); chk("R7 first converter ch2 intact", 32'(v), 32'hBEEF);
   endtask

   task automatic t_busy;
      logic [7:0]  b;
      logic [15:0] v;
      stage(1, 16'hAAAA);
      wr(6, 8'h30);
      stage(1, 16'h5555);
      wr(6, 8'h7F);
      wait_ready(1);
      chk("R8 frame not restarted", 32'(cap1), 32'h30AAAA);
      rd(6, b);
      chk("R8 command register kept", 32'(b), 32'h30);
      readback(1, 8'hB0, v); chk("R8 first applied", 32'(v), 32'hAAAA);
      readback(1, 8'hD6, v); chk("R8 ignored not applied", 32'(v), 32'h0);
   endtask

   task automatic t_nop;
      logic [15:0] v;
      issue(1, 16'h9999, 8'hF0);
      chk("R9 idle opcode frame", 32'(cap1), 32'hF09999);
      readback(1, 8'hB0, v); chk("R9 idle opcode no change", 32'(v), 32'hAAAA);
      issue(1, 16'h7777, 8'h0F);
      readback(1, 8'hB6, v); chk("R9 unassigned opcode no input change", 32'(v), 32'h0);
      issue(1, 16'h7777, 8'hEF);
      readback(1, 8'hD6, v); chk("R9 unassigned opcode no active change", 32'(v), 32'h0);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_frame;
      t_update;
      t_readback;
      t_combined;
      t_second;
      t_busy;
      t_nop;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule